// File: doc/BRIEF.md
# Preamble-Based Read Sampling Phase Calibrator

This block chooses the sampling phase for read data on a serial flash link. It recalibrates on every read. A known preamble arrives between the dummy cycles and the data. While that preamble is on the wires, the block sees each bit as it was sampled at sixteen candidate clock phases, one input bit per phase per cycle. It checks every phase against a programmable reference pattern and keeps the phases that reproduced the whole pattern. It then places the new selection at the centre of the widest block of adjacent passing phases. Because the preamble is in-band, the flash needs no tuning pattern stored in advance.

A sequencer walks each read through its phases in the fixed order: command, address, mode, dummy, learn, data. The cycle counts of the first four phases are configuration inputs, and a zero count skips that phase. The learn phase lasts one cycle per pattern bit. The data phase lasts until the host marks the end of the read. The new selection is presented as a phase index on the first data cycle, together with a one-cycle pulse that reports success or failure.

Top module: `preamble_phase_cal`

## Requirements
- R1: After an accepted start, `txn_phase` steps through command (1), address (2), mode (3), dummy (4), learn (5) and data (6). The first four phases each last the number of cycles given on their count input, and a zero count skips that phase. Idle is encoded 0. The first non-skipped phase is visible in the cycle after start is sampled.
- R2: `start` is accepted only in idle. When it is accepted, the counts, the pattern length and the reference pattern are captured. A start pulse or a change to any configuration input during a transaction has no effect on that transaction.
- R3: The learn phase lasts L cycles, where L is `pat_len` limited to the range 8 to 32. Reference bit `pat_ref[L-1]` is compared in the first learn cycle and `pat_ref[0]` in the last.
- R4: Phase i passes only if `samp_bits[i]` equals the reference bit in every one of the L learn cycles. A single mismatch in any cycle, first or last included, fails that phase.
- R5: The selected phase is floor((lo+hi)/2), where lo..hi is the longest run of adjacent passing phases. There is no wraparound between phase 15 and phase 0. When runs tie in length, the run with the lowest index wins.
- R6: On success, `phase_sel` takes its new value in the first data cycle, and `cal_done` is high for exactly that cycle. At all other times `phase_sel` is stable.
- R7: If no phase passes, `phase_sel` keeps its previous value, and `cal_fail` is high for exactly the first data cycle. `cal_done` and `cal_fail` are never high together.
- R8: The data phase lasts until `end_rd` is sampled high. The next cycle is idle.
- R9: Synchronous active-high reset sets `phase_sel` to 0, sets `txn_phase` to idle (0) and clears both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a read transaction (accepted in idle only) |
| end_rd | input | 1 | Ends the data phase |
| cmd_cycles | input | CW (4) | Command phase length in cycles, 0 skips |
| addr_cycles | input | CW (4) | Address phase length in cycles, 0 skips |
| mode_cycles | input | CW (4) | Mode phase length in cycles, 0 skips |
| dummy_cycles | input | CW (4) | Dummy phase length in cycles, 0 skips |
| pat_len | input | LW (6) | Pattern length in bits, limited to 8..32 |
| pat_ref | input | MAXP (32) | Reference pattern, bit L-1 compared first |
| samp_bits | input | NPH (16) | Current line bit as sampled at each candidate phase |
| txn_phase | output | 3 | Transaction phase code (0 idle ... 6 data) |
| phase_sel | output | log2(NPH) (4) | Selected sampling phase |
| cal_done | output | 1 | One-cycle pulse: new phase applied |
| cal_fail | output | 1 | One-cycle pulse: no phase passed |

## Verification
The assertions check the following on every cycle:
- `phase_sel` moves only on the edge that ends learning.
- The two pulses are exclusive and occur only on entry to data.
- A failed calibration leaves the selection unchanged.
- The chosen index is itself a passing phase.
- Data is entered only from learn.
- Learning lasts more than one cycle.
- `end_rd` returns the sequencer to idle.

Only the bench scenarios can show the following:
- The exact phase durations.
- The skipping of zero-count phases.
- The clamping of the pattern length and the MSB-first bit order.
- The selection of the centre of the longest run, with its tie and gap cases.
- That stray start pulses and late configuration changes are ignored.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_MODE  = 3'd3,
    PH_DUMMY = 3'd4,
    PH_LEARN = 3'd5,
    PH_DATA  = 3'd6
  } ph_e;

  // Limit a raw length into [lo, hi].
  function automatic int unsigned clamp_len(int unsigned raw, int unsigned lo, int unsigned hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

endpackage

// File: rtl/cal_seq.sv
module cal_seq
  import cal_pkg::*;
#(
  parameter int CW   = 4,
  parameter int LW   = 6,
  parameter int MINP = 8,
  parameter int MAXP = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            end_rd,
  input  logic [CW-1:0]   cmd_cycles,
  input  logic [CW-1:0]   addr_cycles,
  input  logic [CW-1:0]   mode_cycles,
  input  logic [CW-1:0]   dummy_cycles,
  input  logic [LW-1:0]   pat_len,
  input  logic [MAXP-1:0] pat_ref,
  output ph_e             state,
  output logic            learn_on,
  output logic            learn_last,
  output logic            ref_bit
);

  localparam int LCW = $clog2(MAXP + 1);
  localparam int KW  = (CW > LCW) ? CW : LCW;
  localparam int PIW = $clog2(MAXP);

  ph_e             st;
  logic [KW-1:0]   cnt;
  logic [CW-1:0]   c_q, a_q, m_q, d_q;
  logic [KW-1:0]   len_q;
  logic [MAXP-1:0] ref_q;

  logic [CW-1:0]   c_s, a_s, m_s, d_s;
  logic [KW-1:0]   len_s, len_live;
  ph_e             nxt_ph;
  logic [KW-1:0]   nxt_len;

  // Next phase after 'cur', skipping zero-count phases among cmd..dummy.
  function automatic ph_e step_phase(ph_e cur, logic [CW-1:0] c, logic [CW-1:0] a,
                                     logic [CW-1:0] m, logic [CW-1:0] d);
    logic [3:0] nz;
    ph_e        res;
    logic       found;
    int         idx;
    nz    = {d != '0, m != '0, a != '0, c != '0};
    idx   = int'(cur);
    res   = PH_LEARN;
    found = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (k >= idx && nz[k] && !found) begin
        res   = ph_e'(k + 1);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic [KW-1:0] phase_len(ph_e p, logic [CW-1:0] c, logic [CW-1:0] a,
                                              logic [CW-1:0] m, logic [CW-1:0] d,
                                              logic [KW-1:0] l);
    case (p)
      PH_CMD:   return KW'(c);
      PH_ADDR:  return KW'(a);
      PH_MODE:  return KW'(m);
      PH_DUMMY: return KW'(d);
      default:  return l;
    endcase
  endfunction

  always_comb begin
    len_live = KW'(clamp_len(int'(pat_len), MINP, MAXP));
    if (st == PH_IDLE) begin
      c_s = cmd_cycles;  a_s = addr_cycles;
      m_s = mode_cycles; d_s = dummy_cycles;
      len_s = len_live;
    end else begin
      c_s = c_q; a_s = a_q; m_s = m_q; d_s = d_q;
      len_s = len_q;
    end
    nxt_ph  = step_phase(st, c_s, a_s, m_s, d_s);
    nxt_len = phase_len(nxt_ph, c_s, a_s, m_s, d_s, len_s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= PH_IDLE;
      cnt   <= '0;
      c_q   <= '0;
      a_q   <= '0;
      m_q   <= '0;
      d_q   <= '0;
      len_q <= KW'(MINP);
      ref_q <= '0;
    end else begin
      case (st)
        PH_IDLE: begin
          if (start) begin
            c_q   <= cmd_cycles;
            a_q   <= addr_cycles;
            m_q   <= mode_cycles;
            d_q   <= dummy_cycles;
            len_q <= len_live;
            ref_q <= pat_ref;
            st    <= nxt_ph;
            cnt   <= nxt_len - KW'(1);
          end
        end
        PH_DATA: begin
          if (end_rd) st <= PH_IDLE;
        end
        default: begin
          if (cnt == '0) begin
            if (st == PH_LEARN) begin
              st <= PH_DATA;
            end else begin
              st  <= nxt_ph;
              cnt <= nxt_len - KW'(1);
            end
          end else begin
            cnt <= cnt - KW'(1);
          end
        end
      endcase
    end
  end

  assign state      = st;
  assign learn_on   = (st == PH_LEARN);
  assign learn_last = (st == PH_LEARN) && (cnt == '0);
  assign ref_bit    = ref_q[cnt[PIW-1:0]];

endmodule

// File: rtl/cal_lane.sv
module cal_lane (
  input  logic clk,
  input  logic rst,
  input  logic learn_on,
  input  logic smp,
  input  logic ref_bit,
  output logic pass_now
);

  logic ok_q;
  logic hit;

  assign hit = (smp == ref_bit);

  always_ff @(posedge clk) begin
    if (rst || !learn_on) ok_q <= 1'b1;
    else                  ok_q <= ok_q & hit;
  end

  // Includes the current cycle so the last learn bit counts.
  assign pass_now = ok_q & hit;

endmodule

// File: rtl/cal_pick.sv
module cal_pick #(
  parameter int NPH = 16,
  parameter int SW  = $clog2(NPH)
) (
  input  logic [NPH-1:0] pass_vec,
  output logic           any,
  output logic [SW-1:0]  sel
);

  // Centre of the longest run of ones, lowest run on ties, no wraparound.
  function automatic int centre_of_run(logic [NPH-1:0] v);
    int best_lo, best_len, run_lo, run_len;
    best_lo = 0; best_len = 0; run_lo = 0; run_len = 0;
    for (int i = 0; i < NPH; i++) begin
      if (v[i]) begin
        if (run_len == 0) run_lo = i;
        run_len++;
        if (run_len > best_len) begin
          best_len = run_len;
          best_lo  = run_lo;
        end
      end else begin
        run_len = 0;
      end
    end
    if (best_len == 0) return 0;
    return (2 * best_lo + best_len - 1) / 2;
  endfunction

  assign any = |pass_vec;
  assign sel = SW'(centre_of_run(pass_vec));

endmodule

// File: rtl/preamble_phase_cal.sv
module preamble_phase_cal
  import cal_pkg::*;
#(
  parameter int NPH  = 16,
  parameter int MAXP = 32,
  parameter int MINP = 8,
  parameter int CW   = 4,
  parameter int LW   = 6,
  localparam int SW  = $clog2(NPH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            end_rd,
  input  logic [CW-1:0]   cmd_cycles,
  input  logic [CW-1:0]   addr_cycles,
  input  logic [CW-1:0]   mode_cycles,
  input  logic [CW-1:0]   dummy_cycles,
  input  logic [LW-1:0]   pat_len,
  input  logic [MAXP-1:0] pat_ref,
  input  logic [NPH-1:0]  samp_bits,
  output logic [2:0]      txn_phase,
  output logic [SW-1:0]   phase_sel,
  output logic            cal_done,
  output logic            cal_fail
);

  ph_e            state;
  logic           learn_on;
  logic           learn_last;
  logic           ref_bit;
  logic [NPH-1:0] pass_vec;
  logic           pick_any;
  logic [SW-1:0]  pick_sel;

  cal_seq #(.CW(CW), .LW(LW), .MINP(MINP), .MAXP(MAXP)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .end_rd       (end_rd),
    .cmd_cycles   (cmd_cycles),
    .addr_cycles  (addr_cycles),
    .mode_cycles  (mode_cycles),
    .dummy_cycles (dummy_cycles),
    .pat_len      (pat_len),
    .pat_ref      (pat_ref),
    .state        (state),
    .learn_on     (learn_on),
    .learn_last   (learn_last),
    .ref_bit      (ref_bit)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_lane
    cal_lane u_lane (
      .clk      (clk),
      .rst      (rst),
      .learn_on (learn_on),
      .smp      (samp_bits[g]),
      .ref_bit  (ref_bit),
      .pass_now (pass_vec[g])
    );
  end

  cal_pick #(.NPH(NPH), .SW(SW)) u_pick (
    .pass_vec (pass_vec),
    .any      (pick_any),
    .sel      (pick_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_sel <= '0;
      cal_done  <= 1'b0;
      cal_fail  <= 1'b0;
    end else begin
      cal_done <= learn_last & pick_any;
      cal_fail <= learn_last & ~pick_any;
      if (learn_last && pick_any) phase_sel <= pick_sel;
    end
  end

  assign txn_phase = state;

endmodule

// File: rtl/cal_chk.sv
module cal_chk #(
  parameter int NPH = 16,
  parameter int SW  = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           end_rd,
  input logic [2:0]     txn_phase,
  input logic [SW-1:0]  phase_sel,
  input logic           cal_done,
  input logic           cal_fail,
  input logic           learn_last,
  input logic [NPH-1:0] pass_vec,
  input logic           pick_any,
  input logic [SW-1:0]  pick_sel
);
  import cal_pkg::*;

  a_r1_data_after_learn: assert property (@(posedge clk) disable iff (rst)
    (txn_phase == PH_DATA && $past(txn_phase) != PH_DATA) |-> $past(txn_phase) == PH_LEARN);

  a_r3_learn_not_single: assert property (@(posedge clk) disable iff (rst)
    (txn_phase == PH_LEARN && $past(txn_phase) != PH_LEARN) |=> txn_phase == PH_LEARN);

  a_r5_sel_is_passing: assert property (@(posedge clk) disable iff (rst)
    pick_any |-> pass_vec[pick_sel]);

  a_r6_sel_stable: assert property (@(posedge clk) disable iff (rst)
    !learn_last |=> $stable(phase_sel));

  a_r6_done_on_entry: assert property (@(posedge clk) disable iff (rst)
    cal_done |-> (txn_phase == PH_DATA && $past(learn_last)));

  a_r7_fail_keeps_sel: assert property (@(posedge clk) disable iff (rst)
    cal_fail |-> (phase_sel == $past(phase_sel) && $past(learn_last)));

  a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cal_done && cal_fail));

  a_r8_end_to_idle: assert property (@(posedge clk) disable iff (rst)
    (txn_phase == PH_DATA && end_rd) |=> txn_phase == PH_IDLE);

endmodule

bind preamble_phase_cal cal_chk #(.NPH(NPH), .SW(SW)) u_cal_chk (
  .clk        (clk),
  .rst        (rst),
  .end_rd     (end_rd),
  .txn_phase  (txn_phase),
  .phase_sel  (phase_sel),
  .cal_done   (cal_done),
  .cal_fail   (cal_fail),
  .learn_last (learn_last),
  .pass_vec   (pass_vec),
  .pick_any   (pick_any),
  .pick_sel   (pick_sel)
);

// File: tb/test_preamble_phase_cal.sv
module test_preamble_phase_cal;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        end_rd = 1'b0;
  logic [3:0]  cmd_cycles = '0, addr_cycles = '0, mode_cycles = '0, dummy_cycles = '0;
  logic [5:0]  pat_len = 6'd8;
  logic [31:0] pat_ref = '0;
  logic [15:0] samp_bits = '0;
  logic [2:0]  txn_phase;
  logic [3:0]  phase_sel;
  logic        cal_done, cal_fail;

  int n_chk = 0;
  int n_fail = 0;
  int cur_sel = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  preamble_phase_cal i_preamble_phase_cal (
    .clk(clk), .rst(rst), .start(start), .end_rd(end_rd),
    .cmd_cycles(cmd_cycles), .addr_cycles(addr_cycles),
    .mode_cycles(mode_cycles), .dummy_cycles(dummy_cycles),
    .pat_len(pat_len), .pat_ref(pat_ref), .samp_bits(samp_bits),
    .txn_phase(txn_phase), .phase_sel(phase_sel),
    .cal_done(cal_done), .cal_fail(cal_fail)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference selection: scan every passing interval, keep the widest, lowest first.
  function automatic int ref_pick(logic [15:0] v);
    int blo = -1, bhi = -1;
    for (int a = 0; a < 16; a++) begin
      for (int b = a; b < 16; b++) begin
        bit all = 1'b1;
        for (int k = a; k <= b; k++) all &= v[k];
        if (all && (blo < 0 || (b - a) > (bhi - blo))) begin
          blo = a; bhi = b;
        end
      end
    end
    return (blo + bhi) >> 1;
  endfunction

  task automatic run_txn(int cc, int ac, int mc, int dc, int lraw,
                         logic [31:0] rf, logic [15:0] vmask, bit poke);
    int L, seq[$], mk[16], k, exp_sel;
    L = (lraw < 8) ? 8 : ((lraw > 32) ? 32 : lraw);
    for (int i = 0; i < 16; i++) mk[i] = $urandom_range(0, L - 1);
    for (int i = 0; i < cc; i++) seq.push_back(1);
    for (int i = 0; i < ac; i++) seq.push_back(2);
    for (int i = 0; i < mc; i++) seq.push_back(3);
    for (int i = 0; i < dc; i++) seq.push_back(4);
    for (int i = 0; i < L; i++)  seq.push_back(5);

    @(negedge clk);
    cmd_cycles = 4'(cc); addr_cycles = 4'(ac); mode_cycles = 4'(mc); dummy_cycles = 4'(dc);
    pat_len = 6'(lraw); pat_ref = rf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: configuration changes after start must not matter
    cmd_cycles = 4'($urandom); addr_cycles = 4'($urandom); mode_cycles = 4'($urandom);
    dummy_cycles = 4'($urandom); pat_len = 6'($urandom); pat_ref = $urandom;
    k = 0;
    foreach (seq[j]) begin
      if (j > 0) @(negedge clk);
      check(txn_phase == 3'(seq[j]), "R1", "phase sequence", txn_phase, seq[j]);
      start = 1'b0;
      if (seq[j] == 5) begin
        int b = L - 1 - k;
        for (int i = 0; i < 16; i++)
          samp_bits[i] = (vmask[i] || k != mk[i]) ? rf[b] : ~rf[b];
        if (poke && k == 2) start = 1'b1;   // R2 stray start in learn
        k++;
      end
    end
    @(negedge clk);
    start = 1'b0;
    samp_bits = 16'($urandom);
    check(txn_phase == 3'd6, "R3", "data after L learn cycles", txn_phase, 6);
    if (vmask != 0) begin
      exp_sel = ref_pick(vmask);
      check(phase_sel == 4'(exp_sel), "R5", "selected phase", phase_sel, exp_sel);
      check(cal_done == 1'b1 && cal_fail == 1'b0, "R6", "done pulse", {cal_done, cal_fail}, 2);
      cur_sel = exp_sel;
    end else begin
      check(phase_sel == 4'(cur_sel), "R7", "phase kept on fail", phase_sel, cur_sel);
      check(cal_fail == 1'b1 && cal_done == 1'b0, "R7", "fail pulse", {cal_done, cal_fail}, 1);
    end
    @(negedge clk);
    check(!cal_done && !cal_fail, "R6", "pulse lasts one cycle", {cal_done, cal_fail}, 0);
    check(txn_phase == 3'd6, "R8", "data held without end_rd", txn_phase, 6);
    end_rd = 1'b1;
    @(negedge clk);
    end_rd = 1'b0;
    check(txn_phase == 3'd0, "R8", "idle after end_rd", txn_phase, 0);
    check(phase_sel == 4'(cur_sel), "R6", "phase stable after data", phase_sel, cur_sel);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(txn_phase == 3'd0, "R9", "reset phase", txn_phase, 0);
    check(phase_sel == 4'd0, "R9", "reset sel", phase_sel, 0);
    check(!cal_done && !cal_fail, "R9", "reset pulses", {cal_done, cal_fail}, 0);
    rst = 1'b0;
    // R2: start is not needed to be ignored in idle, but data path stays idle without it
    @(negedge clk);
    check(txn_phase == 3'd0, "R2", "idle without start", txn_phase, 0);

    run_txn(1, 2, 1, 3, 16, 32'hA5C3_0F96, 16'hFFFF, 1'b0);  // all pass -> 7 (R5)
    run_txn(0, 0, 0, 0, 8, 32'h0000_00B4, 16'h0000, 1'b0);   // R7 none pass, R1 all skipped
    run_txn(2, 0, 3, 0, 32, 32'h8000_0001, 16'h8000, 1'b1);  // R3 max length, single at 15, R2 poke
    run_txn(1, 1, 0, 1, 3, 32'h0000_0069, 16'h00F0, 1'b0);   // R3 short clamps to 8
    run_txn(0, 1, 0, 0, 50, 32'hDEAD_BEEF, 16'h0F0F, 1'b0);  // R3 long clamps to 32, R5 tie -> 1
    run_txn(3, 0, 0, 2, 12, 32'h0000_0A5A, 16'h3E03, 1'b0);  // R5 longer later run -> 11
    run_txn(1, 0, 0, 0, 10, 32'h0000_02AA, 16'h0001, 1'b0);  // R5 run at 0, no wrap
    run_txn(0, 0, 0, 1, 20, 32'h000F_00F0, 16'h8001, 1'b0);  // R5 ends not joined -> 0
    run_txn(1, 1, 1, 1, 9, 32'h0000_01FF, 16'h0000, 1'b0);   // R4 each lane one bad bit

    for (int t = 0; t < 40; t++) begin
      logic [15:0] v;
      case ($urandom_range(0, 3))
        0: v = 16'($urandom);
        1: begin
             int lo = $urandom_range(0, 15);
             int hi = $urandom_range(lo, 15);
             v = '0;
             for (int i = lo; i <= hi; i++) v[i] = 1'b1;
           end
        2: v = 16'($urandom) & 16'($urandom);
        default: v = (t % 7 == 0) ? 16'h0000 : 16'($urandom) | 16'h0100;
      endcase
      run_txn($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 2),
              $urandom_range(0, 4), $urandom_range(4, 40), $urandom, v, t[0]);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule